// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block is the device side of a three-wire serial memory: a chip select, a serial clock and a serial data input come in, and one serial data output goes back. The block holds a 1 Kbit register array. A static configuration pin sets how the host sees it. In one setting it is 128 locations of 8 bits. In the other it is 64 locations of 16 bits. The host frames every instruction with a start bit, then sends a two-bit opcode, an address and, for store operations, data.

The block decodes these instructions: fetch, store, wipe one location, fill all locations, clear all locations, unlock and lock. Unlock and lock control a write-permission latch. Fetch can stream: while select stays high, locations follow one another without a gap and wrap at the end of the array. A store-type operation starts when select falls after its last bit. It then occupies the block for a programmable number of serial clock periods. During that time the output line reports the busy/ready status.

The serial inputs are sampled on a fast system clock, and edges of the serial clock are detected internally.

Top module: `mw_eeprom`

## Requirements
- R1: An instruction starts only when `sel` rises while `sclk` is low. The first 1 sampled on `sdi` at a rising `sclk` edge is the start bit, and zeros before it are skipped. If `sel` rises while `sclk` is high, the block ignores everything until `sel` falls.
- R2: The two bits after the start bit are the opcode: 10 fetch, 01 store, 11 wipe, 00 extended group.
- R3: `org`=1 selects 64x16 with a 6-bit address and 16 data bits. `org`=0 selects 128x8 with a 7-bit address and 8 data bits. In 8-bit mode, byte address b maps to bits [15:8] of word b>>1 when bit 0 of b is 1, and to bits [7:0] of that word when it is 0.
- R4: In the extended group, the top two address bits select the operation: 11 unlock, 00 lock, 10 clear all, 01 fill all. The other address bits are ignored.
- R5: A fetch drives `sdo` to 0 on the `sclk` rise that samples the last address bit. Each following `sclk` rise presents the next data bit, MSB first. `sdo` changes only after an `sclk` rise.
- R6: While `sel` stays high, a fetch continues with the next address and no extra zero bit, and wraps from the last address to 0.
- R7: Reset clears the write-permission latch. Unlock sets it and lock clears it. Store, wipe, clear-all and fill-all leave the array unchanged while it is clear.
- R8: Fetch returns array contents whether the latch is set or clear.
- R9: Store and fill take the data bits after the address, MSB first. Wipe and clear-all set the target bits to all ones. In 8-bit mode, fill writes its byte into both halves of every word.
- R10: Dropping `sel` before an instruction's last bit abandons it with the array unchanged. A store-type operation begins when `sel` falls after its last bit.
- R11: A store-type operation lasts PROG_CYC `sclk` rises. While it runs, `sdo` is 0 and select edges and instructions are ignored. If `sel` is high when it ends, `sdo` becomes 1.
- R12: `sdo` rests at 1 after reset and whenever no fetch or programming operation is driving it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| org | input | 1 | Organisation: 1 = 64x16, 0 = 128x8 |
| sel | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data and busy/ready status out |

## Verification
The assertions assume that `sel`, `sclk` and `sdi` are synchronous to `clk`, that each level of `sclk` lasts at least one `clk` cycle, and that `org` stays fixed while an instruction is in progress. The bench changes every serial line on a falling edge of `clk` and holds each `sclk` phase for four system clocks. It changes `sdi` only while `sclk` is low, and it changes `org` only between instructions, with `sel` low.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_RD,
    ST_WFALL,
    ST_BUSY,
    ST_HOLD
  } mw_state_e;

  typedef enum logic [1:0] {
    OP_GROUP = 2'b00,
    OP_STORE = 2'b01,
    OP_FETCH = 2'b10,
    OP_WIPE  = 2'b11
  } mw_op_e;

  typedef enum logic [1:0] {
    XC_LOCK   = 2'b00,
    XC_FILL   = 2'b01,
    XC_CLEAR  = 2'b10,
    XC_UNLOCK = 2'b11
  } mw_xop_e;

endpackage

// File: rtl/mw_rst_sync.sv
module mw_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int WAW = 6,
  parameter int WW  = 16,
  localparam int DEPTH = 1 << WAW,
  localparam int BW    = WW / 2
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic           wr_all,
  input  logic           byte_mode,
  input  logic           wr_half,
  input  logic [WAW-1:0] wr_idx,
  input  logic [WW-1:0]  wr_data,
  input  logic [WAW-1:0] rd_idx,
  output logic [WW-1:0]  rd_data
);
  logic [DEPTH-1:0][WW-1:0] words;

  // Storage cells carry no reset: contents are undefined until written.
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WW-1:0] word_q;
    logic [WW-1:0] word_d;
    logic          hit;

    assign hit = wr_en && (wr_all || (wr_idx == WAW'(i)));

    always_comb begin
      if (!byte_mode)  word_d = wr_data;
      else if (wr_all) word_d = {wr_data[BW-1:0], wr_data[BW-1:0]};
      else if (wr_half) word_d = {wr_data[BW-1:0], word_q[BW-1:0]};
      else             word_d = {word_q[WW-1:BW], wr_data[BW-1:0]};
    end

    always_ff @(posedge clk) begin
      if (hit) word_q <= word_d;
    end

    assign words[i] = word_q;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int WAW      = 6,
  parameter int WW       = 16,
  parameter int PROG_CYC = 8,
  localparam int BAW = WAW + 1,
  localparam int BW  = WW / 2,
  localparam int CW  = $clog2(WW + 1),
  localparam int PW  = $clog2(PROG_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           org,
  input  logic           sel,
  input  logic           sclk,
  input  logic           sdi,
  output logic           sdo,
  output logic [WAW-1:0] rd_idx,
  input  logic [WW-1:0]  rd_data,
  output logic           wr_en,
  output logic           wr_all,
  output logic           wr_byte,
  output logic           wr_half,
  output logic [WAW-1:0] wr_idx,
  output logic [WW-1:0]  wr_data
);
  mw_state_e      state_q, state_d;
  mw_op_e         op_q, op_d;
  logic           sclk_q, sel_q;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [BAW-1:0] addr_q, addr_d;
  logic [WW-1:0]  data_q, data_d;
  logic [WW-1:0]  osh_q, osh_d;
  logic           obit_q, obit_d;
  logic [CW-1:0]  ocnt_q, ocnt_d;
  logic           wen_q, wen_d;
  logic [PW-1:0]  pcnt_q, pcnt_d;

  logic           c_rise, s_rise;
  logic [CW-1:0]  last_a, last_d;
  logic [BAW-1:0] addr_sh, addr_inc;
  logic [1:0]     xc_sh, xc_q;
  logic [BW-1:0]  rd_byte;
  logic [WW-1:0]  rd_just;
  logic           erase_op;

  assign c_rise = sclk && !sclk_q;
  assign s_rise = sel && !sel_q;

  assign last_a   = org ? CW'(WAW - 1) : CW'(BAW - 1);
  assign last_d   = org ? CW'(WW - 1)  : CW'(BW - 1);
  assign addr_sh  = {addr_q[BAW-2:0], sdi};
  assign addr_inc = org ? {1'b0, addr_q[WAW-1:0] + WAW'(1)} : addr_q + BAW'(1);
  assign xc_sh    = org ? addr_sh[WAW-1 -: 2] : addr_sh[BAW-1 -: 2];
  assign xc_q     = org ? addr_q[WAW-1 -: 2]  : addr_q[BAW-1 -: 2];

  // Read path: word index and left-justified unit for MSB-first shifting.
  assign rd_idx  = org ? addr_q[WAW-1:0] : addr_q[BAW-1:1];
  assign rd_byte = addr_q[0] ? rd_data[WW-1:BW] : rd_data[BW-1:0];
  assign rd_just = org ? rd_data : {rd_byte, {BW{1'b0}}};

  // Commit path, active in the cycle select falls after a complete store-type frame.
  assign erase_op = (op_q == OP_WIPE) || ((op_q == OP_GROUP) && (mw_xop_e'(xc_q) == XC_CLEAR));
  assign wr_en    = (state_q == ST_WFALL) && !sel && wen_q;
  assign wr_all   = (op_q == OP_GROUP);
  assign wr_byte  = !org;
  assign wr_half  = addr_q[0];
  assign wr_idx   = org ? addr_q[WAW-1:0] : addr_q[BAW-1:1];
  assign wr_data  = erase_op ? {WW{1'b1}} : data_q;

  always_comb begin
    unique case (state_q)
      ST_RD:   sdo = obit_q;
      ST_BUSY: sdo = 1'b0;
      default: sdo = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    data_d  = data_q;
    osh_d   = osh_q;
    obit_d  = obit_q;
    ocnt_d  = ocnt_q;
    wen_d   = wen_q;
    pcnt_d  = pcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (s_rise) state_d = sclk ? ST_HOLD : ST_START;
      end
      ST_START: begin
        if (!sel) state_d = ST_IDLE;
        else if (c_rise && sdi) begin
          state_d = ST_OPC;
          cnt_d   = '0;
        end
      end
      ST_OPC: begin
        if (!sel) state_d = ST_IDLE;
        else if (c_rise) begin
          op_d = mw_op_e'({op_q[0], sdi});
          if (cnt_q == CW'(1)) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
            addr_d  = '0;
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      ST_ADDR: begin
        if (!sel) state_d = ST_IDLE;
        else if (c_rise) begin
          addr_d = addr_sh;
          if (cnt_q == last_a) begin
            cnt_d  = '0;
            data_d = '0;
            unique case (op_q)
              OP_FETCH: begin
                state_d = ST_RD;
                obit_d  = 1'b0;
                ocnt_d  = '0;
                addr_d  = org ? {1'b0, addr_sh[WAW-1:0]} : addr_sh;
              end
              OP_STORE: state_d = ST_DATA;
              OP_WIPE:  state_d = ST_WFALL;
              default: begin
                unique case (mw_xop_e'(xc_sh))
                  XC_UNLOCK: begin wen_d = 1'b1; state_d = ST_HOLD; end
                  XC_LOCK:   begin wen_d = 1'b0; state_d = ST_HOLD; end
                  XC_FILL:   state_d = ST_DATA;
                  default:   state_d = ST_WFALL;
                endcase
              end
            endcase
          end else begin
            cnt_d = cnt_q + CW'(1);
          end
        end
      end
      ST_DATA: begin
        if (!sel) state_d = ST_IDLE;
        else if (c_rise) begin
          data_d = {data_q[WW-2:0], sdi};
          if (cnt_q == last_d) state_d = ST_WFALL;
          else                 cnt_d = cnt_q + CW'(1);
        end
      end
      ST_RD: begin
        if (!sel) state_d = ST_IDLE;
        else if (c_rise) begin
          if (ocnt_q == '0) begin
            obit_d = rd_just[WW-1];
            osh_d  = rd_just << 1;
            ocnt_d = last_d;
            addr_d = addr_inc;
          end else begin
            obit_d = osh_q[WW-1];
            osh_d  = osh_q << 1;
            ocnt_d = ocnt_q - CW'(1);
          end
        end
      end
      ST_WFALL: begin
        if (!sel) begin
          if (wen_q) begin
            state_d = ST_BUSY;
            pcnt_d  = PW'(PROG_CYC);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_BUSY: begin
        if (c_rise) begin
          if (pcnt_q == PW'(1)) state_d = sel ? ST_HOLD : ST_IDLE;
          else                  pcnt_d = pcnt_q - PW'(1);
        end
      end
      ST_HOLD: begin
        if (!sel) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_GROUP;
      sclk_q  <= 1'b0;
      sel_q   <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      osh_q   <= '0;
      obit_q  <= 1'b1;
      ocnt_q  <= '0;
      wen_q   <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      sclk_q  <= sclk;
      sel_q   <= sel;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      osh_q   <= osh_d;
      obit_q  <= obit_d;
      ocnt_q  <= ocnt_d;
      wen_q   <= wen_d;
      pcnt_q  <= pcnt_d;
    end
  end

  // R1: a select rise with the serial clock high never opens a frame.
  a_r1_no_start_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && s_rise && sclk) |=> (state_q == ST_HOLD));

  // R5: the fetched bit only moves after a serial clock rise.
  a_r5_bit_holds_between_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD && !c_rise) |=> $stable(obit_q));

  // R7: permission is granted only by a decoded extended-group frame.
  a_r7_unlock_from_group: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wen_q) |-> $past(state_q == ST_ADDR && op_q == OP_GROUP));

  // R10: array updates happen only on a select fall.
  a_r10_commit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!sel && $past(sel)));

  // R11: a programming operation leaves only for idle or hold, never into a frame.
  a_r11_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BUSY) |=> (state_q inside {ST_BUSY, ST_IDLE, ST_HOLD}));

endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int WAW      = 6,
  parameter int WW       = 16,
  parameter int PROG_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org,
  input  logic sel,
  input  logic sclk,
  input  logic sdi,
  output logic sdo
);
  logic           rst_n_s;
  logic [WAW-1:0] rd_idx;
  logic [WW-1:0]  rd_data;
  logic           wr_en, wr_all, wr_byte, wr_half;
  logic [WAW-1:0] wr_idx;
  logic [WW-1:0]  wr_data;

  mw_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mw_ctrl #(.WAW(WAW), .WW(WW), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .org     (org),
    .sel     (sel),
    .sclk    (sclk),
    .sdi     (sdi),
    .sdo     (sdo),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_all  (wr_all),
    .wr_byte (wr_byte),
    .wr_half (wr_half),
    .wr_idx  (wr_idx),
    .wr_data (wr_data)
  );

  mw_array #(.WAW(WAW), .WW(WW)) u_array (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_all    (wr_all),
    .byte_mode (wr_byte),
    .wr_half   (wr_half),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
  );
endmodule

// File: tb/mw_eeprom_tb.sv
module mw_eeprom_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int PROG       = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic org = 1'b1;
  logic sel = 1'b0;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] mdl [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.WAW(6), .WW(16), .PROG_CYC(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .org(org), .sel(sel),
    .sclk(sclk), .sdi(sdi), .sdo(sdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int aw();
    return org ? 6 : 7;
  endfunction

  function automatic int dw();
    return org ? 16 : 8;
  endfunction

  function automatic logic [15:0] unit_at(input int a);
    int m;
    m = org ? (a % 64) : (a % 128);
    if (org) return mdl[m];
    return (m % 2) ? {8'h00, mdl[m/2][15:8]} : {8'h00, mdl[m/2][7:0]};
  endfunction

  task automatic pulse(input logic d, output logic q);
    sdi = d;
    waitc(HALF);
    sclk = 1'b1;
    waitc(HALF);
    q = sdo;
    sclk = 1'b0;
  endtask

  task automatic sbits(input logic [31:0] v, input int n);
    logic q;
    for (int i = n - 1; i >= 0; i--) pulse(v[i], q);
  endtask

  task automatic sel_up();
    sclk = 1'b0;
    waitc(HALF);
    sel = 1'b1;
    waitc(HALF);
  endtask

  task automatic sel_down();
    waitc(HALF);
    sel = 1'b0;
    waitc(HALF);
  endtask

  // Raise select, clock until ready; returns number of clock pulses needed.
  task automatic finish_busy(output int n);
    logic q;
    sel_up();
    n = 0;
    q = sdo;
    while (q == 1'b0 && n < 100) begin
      pulse(1'b0, q);
      n++;
    end
    sel_down();
  endtask

  task automatic store(input int a, input logic [15:0] d, output int n);
    sel_up();
    sbits(3'b101, 3);
    sbits(a, aw());
    sbits(d, dw());
    sel_down();
    finish_busy(n);
  endtask

  task automatic group(input logic [1:0] code, input logic [15:0] d, output int n);
    sel_up();
    sbits(3'b100, 3);
    sbits(32'(code) << (aw() - 2), aw());
    if (code == 2'b01) sbits(d, dw());
    sel_down();
    finish_busy(n);
  endtask

  task automatic fetch(input int start, input int nunits, input string req, input int lead);
    logic q;
    logic [15:0] v;
    sel_up();
    if (lead > 0) sbits(0, lead);
    sbits(3'b110, 3);
    sbits(start >> 1, aw() - 1);
    pulse(start[0], q);
    chk("R5 dummy zero", q, 0);
    for (int w = 0; w < nunits; w++) begin
      v = '0;
      for (int b = 0; b < dw(); b++) begin
        pulse(1'b0, q);
        v = {v[14:0], q};
      end
      chk(req, v, unit_at(start + w));
    end
    sel_down();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    logic q;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    chk("R12 idle output after reset", sdo, 1);

    // R7: store ignored after reset (latch clear): no busy phase.
    org = 1'b1;
    store(1, 16'h0BAD, n);
    chk("R7 store ignored after reset, busy pulses", n, 0);

    // R4 unlock + clear all; R9 erase-all gives ones.
    group(2'b11, 16'h0, n);
    group(2'b10, 16'h0, n);
    chk("R4 clear-all busy pulses", n, PROG);
    for (int i = 0; i < 64; i++) mdl[i] = 16'hFFFF;
    fetch(0, 4, "R9 clear-all ones", 0);

    // R7 lock: store ignored; R8 fetch while locked.
    group(2'b00, 16'h0, n);
    store(3, 16'h1234, n);
    chk("R7 store while locked, busy pulses", n, 0);
    fetch(3, 1, "R8 fetch while locked", 0);

    // R2/R9: store sweep over every word, then one streaming fetch with wrap (R6).
    group(2'b11, 16'h0, n);
    for (int a = 0; a < 64; a++) begin
      mdl[a] = 16'(a * 16'h0413) ^ 16'hA5C3;
      store(a, mdl[a], n);
    end
    fetch(0, 65, "R6 x16 stream with wrap", 0);

    // R11 busy length and status.
    store(10, 16'hBEEF, n);
    mdl[10] = 16'hBEEF;
    chk("R11 programming length", n, PROG);
    fetch(10, 1, "R9 store data msb first", 0);

    // R11 instruction during busy is ignored.
    sel_up();
    sbits(3'b101, 3); sbits(11, 6); sbits(16'h1111, 16);
    sel_down();
    mdl[11] = 16'h1111;
    sel_up();
    chk("R11 status low while busy", sdo, 0);
    sbits(3'b101, 3); sbits(7, 6); sbits(16'h7777, 16);
    sel_down();
    finish_busy(n);
    chk("R11 remaining busy pulses", n, PROG - 25);
    fetch(7, 1, "R11 store during busy ignored", 0);
    fetch(11, 1, "R9 store before busy", 0);

    // R9 wipe single word.
    sel_up(); sbits(3'b111, 3); sbits(5, 6); sel_down();
    finish_busy(n);
    mdl[5] = 16'hFFFF;
    fetch(5, 1, "R9 wipe gives ones", 0);

    // R10 abort mid-data.
    sel_up(); sbits(3'b101, 3); sbits(2, 6); sbits(8'h00, 8); sel_down();
    finish_busy(n);
    chk("R10 abort starts no busy", n, 0);
    fetch(2, 1, "R10 abort leaves word", 0);

    // R1 leading zeros skipped.
    fetch(20, 2, "R1 leading zeros", 3);

    // R1 select rising with clock high ignored.
    sclk = 1'b1; waitc(HALF);
    sel = 1'b1; waitc(HALF);
    sclk = 1'b0;
    sbits(3'b110, 3); sbits(0, 5);
    pulse(1'b0, q);
    chk("R1 frame ignored with clock high at select", q, 1);
    sel_down();

    // R3 x8 organisation: full byte stream plus wrap.
    org = 1'b0;
    fetch(0, 129, "R3 x8 byte stream", 0);
    store(9, 16'h003C, n);
    mdl[4][15:8] = 8'h3C;
    org = 1'b1;
    fetch(4, 1, "R3 byte lane mapping", 0);

    // R4 fill in x8 mode replicates the byte.
    org = 1'b0;
    group(2'b01, 16'h005A, n);
    chk("R4 fill busy pulses", n, PROG);
    for (int i = 0; i < 64; i++) mdl[i] = 16'h5A5A;
    org = 1'b1;
    fetch(62, 3, "R9 fill all R6 wrap", 0);

    // R7 lock blocks wipe too.
    group(2'b00, 16'h0, n);
    sel_up(); sbits(3'b111, 3); sbits(8, 6); sel_down();
    finish_busy(n);
    fetch(8, 1, "R7 wipe while locked ignored", 0);
    chk("R12 idle output at end", sdo, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule